// File: doc/BRIEF.md
# Transmit Trigger and Interrupt Controller

This block is the control corner of a packet radio controller. Software starts a frame by setting a trigger bit in a transmit-control register over a small register bus, optionally asking that an acknowledgement be awaited. The block holds the request toward a transmit engine until the engine accepts it. When the engine later reports completion, the block records the success or failure and raises a transmit-complete event. A separate receive event input records a frame arrival.

Events collect in an interrupt status register that clears when it is read. A mask register, whose bits disable an interrupt when set, decides which pending events pull the active-low interrupt pin down. Masked events are still recorded and can be polled. Out of reset all interrupts are disabled.

Register offsets on `reg_addr`: 0 = transmit control, 1 = transmit status, 2 = interrupt status, 3 = interrupt mask. All registers are 8 bits wide.

Top module: `txirq_ctrl`

## Requirements
- R1: After reset `irq_n` is 1, `tx_req` is 0, the mask register reads 0x09 (both interrupts disabled), and the interrupt status and transmit status registers read 0x00.
- R2: A write to the transmit-control register with bit 0 set raises `tx_req` from the following cycle; on every such write, `tx_ack_req` takes the value of bit 2 of the written data. A write with bit 0 clear does not start a request.
- R3: `tx_req` stays high, and transmit-control bit 0 reads 1, until `eng_accept` is sampled high while the request is pending; `tx_req` is low in the following cycle. Transmit-control bit 2 reads back the acknowledge-request flag.
- R4: When `eng_done` is sampled high, transmit-status bit 0 takes the value of `eng_fail` (1 means the retry limit was exceeded) and holds it until the next completion.
- R5: When `eng_done` is sampled high, interrupt-status bit 0 (transmit complete) becomes 1; when `rx_evt` is sampled high, interrupt-status bit 3 (frame received) becomes 1.
- R6: Reading the interrupt-status register returns the pending bits and clears them in the same access; an event sampled in the same cycle as that read stays pending after it.
- R7: Mask bit 0 disables the transmit interrupt and mask bit 3 the receive interrupt (1 = disabled, 0 = enabled); `irq_n` is 0 exactly while some pending status bit has its mask bit at 0, and it changes in the cycle after the event, read or mask write that causes it.
- R8: An event whose mask bit is 1 is still recorded in the interrupt-status register and read back, while `irq_n` stays 1.
- R9: Writes to the transmit-status and interrupt-status registers have no effect; bits other than 0 and 2 of transmit control, 0 of transmit status, and 0 and 3 of interrupt status and mask read as 0.
- R10: Each read strobe returns its data on `reg_rdata` with `reg_rvalid` high in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 2 | Register offset |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, valid with reg_rvalid |
| reg_rvalid | output | 1 | Read data valid, one cycle after reg_rd |
| tx_req | output | 1 | Transmit request to the engine |
| tx_ack_req | output | 1 | Acknowledge awaited for the requested frame |
| eng_accept | input | 1 | Engine has taken the request |
| eng_done | input | 1 | Engine finished a frame (one-cycle pulse) |
| eng_fail | input | 1 | Qualifies eng_done: retry limit exceeded |
| rx_evt | input | 1 | A frame was received (one-cycle pulse) |
| irq_n | output | 1 | Active-low interrupt |

## Verification
The assertions take for granted that `reg_wr` and `reg_rd` are never high together, that `eng_done` and `rx_evt` are single-cycle pulses, and that `eng_fail` is meaningful only alongside `eng_done`. The stimulus drives each strobe for exactly one cycle at the falling clock edge and never overlaps a write with a read. It still places a receive event in the very cycle of a status read, and lets a completion arrive while its interrupt is masked, so that the set-over-clear priority and the recording of masked events are exercised.

// File: rtl/txirq_pkg.sv
`timescale 1ns/1ps
package txirq_pkg;

    localparam int DW = 8;
    localparam int AW = 2;

    // bit positions that software decodes
    localparam int TRIG_BIT  = 0;
    localparam int ACKRQ_BIT = 2;
    localparam int FAIL_BIT  = 0;
    localparam int TXEV_BIT  = 0;
    localparam int RXEV_BIT  = 3;

    typedef enum logic [AW-1:0] {
        RA_CTRL  = 2'd0,
        RA_TXST  = 2'd1,
        RA_ISTAT = 2'd2,
        RA_IMASK = 2'd3
    } reg_addr_e;

    typedef struct packed {
        logic rx;
        logic tx;
    } ev_t;

    localparam ev_t EV_NONE = '{rx: 1'b0, tx: 1'b0};
    localparam ev_t EV_ALL  = '{rx: 1'b1, tx: 1'b1};

    function automatic logic [DW-1:0] ev_to_byte(input ev_t e);
        logic [DW-1:0] b;
        b = '0;
        b[TXEV_BIT] = e.tx;
        b[RXEV_BIT] = e.rx;
        return b;
    endfunction

    function automatic ev_t byte_to_ev(input logic [DW-1:0] b);
        ev_t e;
        e.tx = b[TXEV_BIT];
        e.rx = b[RXEV_BIT];
        return e;
    endfunction

    function automatic logic ev_any(input ev_t e);
        return e.tx | e.rx;
    endfunction

endpackage

// File: rtl/txirq_tx_ctrl.sv
`timescale 1ns/1ps
module txirq_tx_ctrl
    import txirq_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          ctrl_wr,
    input  logic [DW-1:0] wdata,
    input  logic          eng_accept,
    input  logic          eng_done,
    input  logic          eng_fail,
    output logic          tx_req,
    output logic          ack_req,
    output logic          tx_failed
);

    logic trig_q;
    logic ack_q;
    logic fail_q;
    logic start_wr;

    assign start_wr = ctrl_wr & wdata[TRIG_BIT];

    // trigger: a new start write wins over acceptance of the old one
    always_ff @(posedge clk) begin
        if (rst) begin
            trig_q <= 1'b0;
        end else if (start_wr) begin
            trig_q <= 1'b1;
        end else if (trig_q && eng_accept) begin
            trig_q <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ack_q <= 1'b0;
        end else if (ctrl_wr) begin
            ack_q <= wdata[ACKRQ_BIT];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            fail_q <= 1'b0;
        end else if (eng_done) begin
            fail_q <= eng_fail;
        end
    end

    assign tx_req    = trig_q;
    assign ack_req   = ack_q;
    assign tx_failed = fail_q;

    // R3: accepted request drops unless re-triggered
    assert_req_drop_R3: assert property (@(posedge clk) disable iff (rst)
        (tx_req && eng_accept && !start_wr) |=> !tx_req);

    // R3: pending request is held while not accepted
    assert_req_hold_R3: assert property (@(posedge clk) disable iff (rst)
        (tx_req && !eng_accept) |=> tx_req);

    // R2: start write raises the request
    assert_req_rise_R2: assert property (@(posedge clk) disable iff (rst)
        start_wr |=> tx_req);

    // R4: failure flag follows the completion qualifier
    assert_fail_latch_R4: assert property (@(posedge clk) disable iff (rst)
        eng_done |=> (tx_failed == $past(eng_fail)));

endmodule

// File: rtl/txirq_evt_status.sv
`timescale 1ns/1ps
module txirq_evt_status
    import txirq_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  ev_t           set_ev,
    input  logic          istat_rd,
    input  logic          mask_wr,
    input  logic [DW-1:0] wdata,
    output ev_t           pend,
    output ev_t           mask
);

    ev_t pend_q;
    ev_t mask_q;
    ev_t pend_d;

    // clear-on-read, then set: an event in the read cycle survives
    always_comb begin
        pend_d = pend_q;
        if (istat_rd) begin
            pend_d = EV_NONE;
        end
        pend_d.tx = pend_d.tx | set_ev.tx;
        pend_d.rx = pend_d.rx | set_ev.rx;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= EV_NONE;
        end else begin
            pend_q <= pend_d;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q <= EV_ALL;
        end else if (mask_wr) begin
            mask_q <= byte_to_ev(wdata);
        end
    end

    assign pend = pend_q;
    assign mask = mask_q;

    // R6: read without a new event leaves nothing pending
    assert_clr_on_read_R6: assert property (@(posedge clk) disable iff (rst)
        (istat_rd && !ev_any(set_ev)) |=> !ev_any(pend));

    // R6: an event in the read cycle is kept
    assert_set_wins_R6: assert property (@(posedge clk) disable iff (rst)
        set_ev.rx |=> pend.rx);

    // R5: completion is recorded
    assert_tx_rec_R5: assert property (@(posedge clk) disable iff (rst)
        set_ev.tx |=> pend.tx);

    // R8: pending bits only leave through a read
    assert_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (pend.tx && !istat_rd) |=> pend.tx);

endmodule

// File: rtl/txirq_irq_gen.sv
`timescale 1ns/1ps
module txirq_irq_gen
    import txirq_pkg::*;
(
    input  ev_t  pend,
    input  ev_t  mask,
    output logic irq_n
);

    ev_t live;

    always_comb begin
        live.tx = pend.tx & ~mask.tx;
        live.rx = pend.rx & ~mask.rx;
    end

    assign irq_n = ~ev_any(live);

endmodule

// File: rtl/txirq_ctrl.sv
`timescale 1ns/1ps
module txirq_ctrl
    import txirq_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          reg_wr,
    input  logic          reg_rd,
    input  logic [AW-1:0] reg_addr,
    input  logic [DW-1:0] reg_wdata,
    output logic [DW-1:0] reg_rdata,
    output logic          reg_rvalid,
    output logic          tx_req,
    output logic          tx_ack_req,
    input  logic          eng_accept,
    input  logic          eng_done,
    input  logic          eng_fail,
    input  logic          rx_evt,
    output logic          irq_n
);

    reg_addr_e     addr;
    logic          ctrl_wr;
    logic          mask_wr;
    logic          istat_rd;
    logic          tx_failed;
    ev_t           set_ev;
    ev_t           pend;
    ev_t           mask;
    logic [DW-1:0] rd_mux;
    logic [DW-1:0] rdata_q;
    logic          rvalid_q;

    assign addr     = reg_addr_e'(reg_addr);
    assign ctrl_wr  = reg_wr && (addr == RA_CTRL);
    assign mask_wr  = reg_wr && (addr == RA_IMASK);
    assign istat_rd = reg_rd && (addr == RA_ISTAT);

    always_comb begin
        set_ev.tx = eng_done;
        set_ev.rx = rx_evt;
    end

    txirq_tx_ctrl u_tx (
        .clk        (clk),
        .rst        (rst),
        .ctrl_wr    (ctrl_wr),
        .wdata      (reg_wdata),
        .eng_accept (eng_accept),
        .eng_done   (eng_done),
        .eng_fail   (eng_fail),
        .tx_req     (tx_req),
        .ack_req    (tx_ack_req),
        .tx_failed  (tx_failed)
    );

    txirq_evt_status u_evt (
        .clk      (clk),
        .rst      (rst),
        .set_ev   (set_ev),
        .istat_rd (istat_rd),
        .mask_wr  (mask_wr),
        .wdata    (reg_wdata),
        .pend     (pend),
        .mask     (mask)
    );

    txirq_irq_gen u_irq (
        .pend  (pend),
        .mask  (mask),
        .irq_n (irq_n)
    );

    always_comb begin
        rd_mux = '0;
        unique case (addr)
            RA_CTRL: begin
                rd_mux[TRIG_BIT]  = tx_req;
                rd_mux[ACKRQ_BIT] = tx_ack_req;
            end
            RA_TXST:  rd_mux[FAIL_BIT] = tx_failed;
            RA_ISTAT: rd_mux = ev_to_byte(pend);
            RA_IMASK: rd_mux = ev_to_byte(mask);
            default:  rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata_q  <= '0;
            rvalid_q <= 1'b0;
        end else begin
            rvalid_q <= reg_rd;
            if (reg_rd) begin
                rdata_q <= rd_mux;
            end
        end
    end

    assign reg_rdata  = rdata_q;
    assign reg_rvalid = rvalid_q;

    // R10: every read strobe answers next cycle
    assert_rvalid_R10: assert property (@(posedge clk) disable iff (rst)
        reg_rd |=> reg_rvalid);

    // R7: the pin only falls after an event or a mask change
    assert_irq_cause_R7: assert property (@(posedge clk) disable iff (rst)
        $fell(irq_n) |-> $past(eng_done || rx_evt || mask_wr));

    // R7: the pin only rises after a status read or a mask change
    assert_irq_release_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(irq_n) |-> $past(istat_rd || mask_wr));

endmodule

// File: tb/txirq_ctrl_bench.sv
`timescale 1ns/1ps
module txirq_ctrl_bench;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       reg_wr = 1'b0;
    logic       reg_rd = 1'b0;
    logic [1:0] reg_addr = 2'd0;
    logic [7:0] reg_wdata = 8'd0;
    logic [7:0] reg_rdata;
    logic       reg_rvalid;
    logic       tx_req;
    logic       tx_ack_req;
    logic       eng_accept = 1'b0;
    logic       eng_done = 1'b0;
    logic       eng_fail = 1'b0;
    logic       rx_evt = 1'b0;
    logic       irq_n;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    logic [7:0] exp_q[$];
    string      tag_q[$];

    always #2.5 clk = ~clk;

    txirq_ctrl u_txirq_ctrl (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .reg_rvalid(reg_rvalid), .tx_req(tx_req), .tx_ack_req(tx_ack_req),
        .eng_accept(eng_accept), .eng_done(eng_done), .eng_fail(eng_fail),
        .rx_evt(rx_evt), .irq_n(irq_n)
    );

    task automatic pin_chk(input string tag, input logic act, input logic exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0b expected %0b", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    // driver: pushes the expected value for the monitor
    task automatic rd(input logic [1:0] a, input logic [7:0] e, input string tag);
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = a;
        exp_q.push_back(e);
        tag_q.push_back(tag);
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic pulse_done(input logic f);
        @(negedge clk);
        eng_done = 1'b1; eng_fail = f;
        @(negedge clk);
        eng_done = 1'b0; eng_fail = 1'b0;
    endtask

    task automatic pulse_rx();
        @(negedge clk);
        rx_evt = 1'b1;
        @(negedge clk);
        rx_evt = 1'b0;
    endtask

    task automatic pulse_accept();
        @(negedge clk);
        eng_accept = 1'b1;
        @(negedge clk);
        eng_accept = 1'b0;
    endtask

    // monitor: compares each returned read (R10 framing)
    always @(negedge clk) begin
        if (!rst && reg_rvalid) begin
            n_cmp++;
            if (exp_q.size() == 0) begin
                n_bad++;
                $display("FAIL R10: unexpected read data actual %02h expected none", reg_rdata);
            end else begin
                logic [7:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                if (reg_rdata !== e) begin
                    n_bad++;
                    $display("FAIL %s: read actual %02h expected %02h", t, reg_rdata, e);
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        pin_chk("R1 irq_n", irq_n, 1'b1);
        pin_chk("R1 tx_req", tx_req, 1'b0);
        rd(2'd3, 8'h09, "R1 mask");
        rd(2'd2, 8'h00, "R1 istat");
        rd(2'd1, 8'h00, "R1 txstat");

        // R2/R3 trigger with ack request
        wr(2'd0, 8'h05);
        pin_chk("R2 tx_req", tx_req, 1'b1);
        pin_chk("R2 ack_req", tx_ack_req, 1'b1);
        rd(2'd0, 8'h05, "R3 pending ctrl");
        repeat (3) @(negedge clk);
        pin_chk("R3 held", tx_req, 1'b1);
        pulse_accept();
        pin_chk("R3 dropped", tx_req, 1'b0);
        rd(2'd0, 8'h04, "R3 ctrl after accept");

        // R8 masked completion recorded, pin quiet
        pulse_done(1'b0);
        pin_chk("R8 irq masked", irq_n, 1'b1);
        rd(2'd1, 8'h00, "R4 success");
        rd(2'd2, 8'h01, "R8 masked recorded");
        rd(2'd2, 8'h00, "R6 cleared");

        // R7 unmasked failure
        wr(2'd3, 8'h00);
        wr(2'd0, 8'h01);
        pin_chk("R2 no ack", tx_ack_req, 1'b0);
        pulse_accept();
        pulse_done(1'b1);
        pin_chk("R7 irq tx", irq_n, 1'b0);
        rd(2'd1, 8'h01, "R4 fail");
        rd(2'd2, 8'h01, "R5 tx bit");
        pin_chk("R6 irq released", irq_n, 1'b1);

        // R5 receive
        pulse_rx();
        pin_chk("R5 irq rx", irq_n, 1'b0);
        rd(2'd2, 8'h08, "R5 rx bit");
        pin_chk("R6 irq released rx", irq_n, 1'b1);

        // R7 selective mask
        wr(2'd3, 8'h01);
        pulse_done(1'b0);
        pin_chk("R7 tx masked", irq_n, 1'b1);
        pulse_rx();
        pin_chk("R7 rx unmasked", irq_n, 1'b0);
        rd(2'd2, 8'h09, "R8 both recorded");
        pin_chk("R7 irq clear", irq_n, 1'b1);

        // R6 event in the read cycle survives
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = 2'd2; rx_evt = 1'b1;
        exp_q.push_back(8'h00); tag_q.push_back("R6 read with event");
        @(negedge clk);
        reg_rd = 1'b0; rx_evt = 1'b0;
        pin_chk("R6 event kept irq", irq_n, 1'b0);
        rd(2'd2, 8'h08, "R6 event kept");

        // R9 ignored writes and unused bits
        wr(2'd2, 8'hFF);
        pin_chk("R9 istat write ignored", irq_n, 1'b1);
        rd(2'd2, 8'h00, "R9 istat");
        wr(2'd1, 8'hFF);
        rd(2'd1, 8'h00, "R9 txstat");
        wr(2'd3, 8'hFF);
        rd(2'd3, 8'h09, "R9 mask unused bits");
        wr(2'd0, 8'hFA);
        pin_chk("R2 no trigger", tx_req, 1'b0);
        rd(2'd0, 8'h00, "R9 ctrl");

        repeat (3) @(negedge clk);
        n_cmp++;
        if (exp_q.size() != 0) begin
            n_bad++;
            $display("FAIL R10: reads left actual %0d expected 0", exp_q.size());
        end
        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule